// File: doc/BRIEF.md
# Voltage-Frequency Operating-Point Sequencer

This block moves a core or cluster from one voltage-frequency operating point to another. The points are held in a small indexed table: each index maps to a supply code for the regulator and a clock-divider select. A level index is requested with a one-cycle strobe. The sequencer then orders the regulator request and the divider change so that the clock is never faster than the supply can carry. Deciding which level to ask for, the regulator's analog ramp and the clock generator itself all live outside this block.

Going up, the supply is raised first and the divider moves only after the regulator has settled. Going down, the divider is slowed first and the supply follows. While the supply ramps upward, a mode input picks one of two behaviours. The core can be held with a stall output, or it can keep executing at the old clock until the supply is settled. A busy flag covers each transition. The reported level changes only once both the supply and the clock match the new point. A request that arrives during a transition is held, and only the newest one is kept.

Top module: `dvfs_seq`

## Requirements
- R1: After a synchronous active-low reset the block reports level 0, requests the supply code of level 0, selects divider NUM_LEVELS-1, and holds stall and busy low.
- R2: Level i maps to supply code V_MIN + i*V_STEP and divider select NUM_LEVELS-1-i. Select 0 is the fastest clock and larger selects are slower. After a transition completes, both outputs hold the values of the requested level.
- R3: The clock level (NUM_LEVELS-1 minus the divider select) never exceeds the lowest supply level that can be present at the time. During a ramp that is the lower of the old and new supply levels.
- R4: On a move upward the supply request changes first. The regulator acknowledge is ignored in the cycle right after that change. The divider switches in the cycle after the acknowledge is then seen high.
- R5: On a move downward the divider changes at the first edge of the transition and the supply request changes one cycle later. The transition ends when the acknowledge is seen high, with the same one-cycle guard as R4.
- R6: With stall_mode high when an upward move begins, core_stall rises at the same edge as the supply request and falls at the same edge as the divider change. It stays high on every cycle in between.
- R7: With stall_mode low when an upward move begins, core_stall stays low and the old divider is kept until the acknowledge. core_stall is never asserted on a downward move.
- R8: A request for the level already reported starts no transition: busy stays low and both supply request and divider stay unchanged.
- R9: A request taken during a transition is served after that transition ends. If several arrive, only the last one is served.
- R10: busy is high from the first edge of a transition to its last. cur_level holds the old level throughout and takes the new value at the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe carrying a new level request |
| req_level | input | LW | Requested table index |
| stall_mode | input | 1 | 1: stall the core during an upward ramp; 0: keep running at the old clock |
| vreg_ack | input | 1 | Regulator reports that the requested supply has settled |
| vreg_req | output | VW | Supply code requested from the regulator |
| clk_div_sel | output | LW | Clock-divider select, 0 is fastest |
| core_stall | output | 1 | Holds the core while the supply ramps (stall mode) |
| busy | output | 1 | A transition is in progress |
| cur_level | output | LW | Level whose supply and clock are both applied |

## Verification
The embedded assertions watch, on every cycle, the cycle-level rules. The clock level must not pass the supply level. A faster divider may appear only right after an acknowledged wait, and a lower supply request only after the divider has already slowed. Stall is never high outside a transition, and an idle sequencer must be at its reported level. Some properties need a model of the regulator and of the request history, and only the bench scenarios show those. One is that a stale acknowledge left high from the last step cannot release the divider early. Others are that queued requests collapse to the newest one, that a request for the present level leaves every output alone, and that the two stall policies differ as required across random levels and regulator delays.

// File: rtl/dvfs_seq_pkg.sv
// Shared types for the operating-point sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dvfs_seq_pkg;

    // Sequencer phases; upward and downward paths are kept apart.
    typedef enum logic [2:0] {
        SQ_IDLE     = 3'd0,
        SQ_UP_GUARD = 3'd1,
        SQ_UP_WAIT  = 3'd2,
        SQ_DN_VSET  = 3'd3,
        SQ_DN_GUARD = 3'd4,
        SQ_DN_WAIT  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/dvfs_optable.sv
// Operating-point lookup: maps a level index to a regulator supply code
// and a clock-divider select. The entries are generated from parameters
// and nothing is stored.
// Assumes: idx < NUM_LEVELS (the request holder clamps it).
module dvfs_optable #(
    parameter int NUM_LEVELS = 8,
    parameter int LW         = 3,
    parameter int VW         = 8,
    parameter int V_MIN      = 60,
    parameter int V_STEP     = 10
) (
    input  logic [LW-1:0] idx,
    output logic [VW-1:0] vcode,
    output logic [LW-1:0] div_sel
);

    logic [VW-1:0] vtab [NUM_LEVELS];
    logic [LW-1:0] dtab [NUM_LEVELS];

    // One generated entry per level: rising supply, shrinking divider.
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_ent
        assign vtab[g] = VW'(V_MIN + g * V_STEP);
        assign dtab[g] = LW'(NUM_LEVELS - 1 - g);
    end

    // Plain indexed read of both columns.
    always_comb begin
        vcode   = vtab[idx];
        div_sel = dtab[idx];
    end

endmodule

// File: rtl/dvfs_req_hold.sv
// Pending-request holder: keeps the newest requested level until the
// sequencer takes it. A later strobe overwrites an untaken one.
// Assumes: take is only raised while pend_vld is high.
module dvfs_req_hold #(
    parameter int NUM_LEVELS = 8,
    parameter int LW         = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [LW-1:0] req_level,
    input  logic          take,
    output logic          pend_vld,
    output logic [LW-1:0] pend_lvl
);

    localparam logic [LW-1:0] TOP_LVL = LW'(NUM_LEVELS - 1);

    logic [LW-1:0] clamped;

    // Clamp indices beyond the table to its top entry.
    always_comb clamped = (req_level > TOP_LVL) ? TOP_LVL : req_level;

    // Hold the newest request; a fresh strobe wins over a take in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_lvl <= '0;
        end else if (req_valid) begin
            pend_vld <= 1'b1;
            pend_lvl <= clamped;
        end else if (take) begin
            pend_vld <= 1'b0;
        end
    end

    // R9
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(take) && !$past(req_valid)) |-> !pend_vld);

    // R9
    newest_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid) |-> (pend_vld && pend_lvl == $past(clamped)));

endmodule

// File: rtl/dvfs_seq_fsm.sv
// Transition controller: orders the supply request and the divider change,
// drives the stall, busy and reported level, and handles the regulator
// handshake with a one-cycle guard after each supply change.
// Assumes: vreg_ack from the regulator is only meaningful from the second
// cycle after vreg_req changes; lk_vcode/lk_div answer lk_idx in the same cycle.
module dvfs_seq_fsm
    import dvfs_seq_pkg::*;
#(
    parameter int NUM_LEVELS = 8,
    parameter int LW         = 3,
    parameter int VW         = 8,
    parameter int V_MIN      = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pend_vld,
    input  logic [LW-1:0] pend_lvl,
    input  logic          stall_mode,
    input  logic          vreg_ack,
    input  logic [VW-1:0] lk_vcode,
    input  logic [LW-1:0] lk_div,
    output logic [LW-1:0] lk_idx,
    output logic          take,
    output logic [VW-1:0] vreg_req,
    output logic [LW-1:0] clk_div_sel,
    output logic          core_stall,
    output logic          busy,
    output logic [LW-1:0] cur_level
);

    localparam logic [VW-1:0] RST_VCODE = VW'(V_MIN);
    localparam logic [LW-1:0] RST_DIV   = LW'(NUM_LEVELS - 1);

    seq_state_t    st_q;
    logic [LW-1:0] tgt_q;
    logic [LW-1:0] cur_q;
    logic [VW-1:0] vreq_q;
    logic [LW-1:0] div_q;
    logic          stall_q;
    logic [LW-1:0] f_lvl_q;   // level the divider currently represents
    logic [LW-1:0] v_lvl_q;   // level the supply request currently represents
    logic          start_ok;

    // Start a transition only for a pending level different from the current one.
    always_comb begin
        start_ok = (st_q == SQ_IDLE) && pend_vld && (pend_lvl != cur_q);
        take     = (st_q == SQ_IDLE) && pend_vld;
        lk_idx   = (st_q == SQ_IDLE) ? pend_lvl : tgt_q;
    end

    // Main sequencing process: one step per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            tgt_q   <= '0;
            cur_q   <= '0;
            vreq_q  <= RST_VCODE;
            div_q   <= RST_DIV;
            stall_q <= 1'b0;
            f_lvl_q <= '0;
            v_lvl_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (start_ok) begin
                        tgt_q <= pend_lvl;
                        if (pend_lvl > cur_q) begin
                            vreq_q  <= lk_vcode;
                            v_lvl_q <= pend_lvl;
                            stall_q <= stall_mode;
                            st_q    <= SQ_UP_GUARD;
                        end else begin
                            div_q   <= lk_div;
                            f_lvl_q <= pend_lvl;
                            st_q    <= SQ_DN_VSET;
                        end
                    end
                end
                SQ_UP_GUARD: st_q <= SQ_UP_WAIT;
                SQ_UP_WAIT: begin
                    if (vreg_ack) begin
                        div_q   <= lk_div;
                        f_lvl_q <= tgt_q;
                        stall_q <= 1'b0;
                        cur_q   <= tgt_q;
                        st_q    <= SQ_IDLE;
                    end
                end
                SQ_DN_VSET: begin
                    vreq_q  <= lk_vcode;
                    v_lvl_q <= tgt_q;
                    st_q    <= SQ_DN_GUARD;
                end
                SQ_DN_GUARD: st_q <= SQ_DN_WAIT;
                SQ_DN_WAIT: begin
                    if (vreg_ack) begin
                        cur_q <= tgt_q;
                        st_q  <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive the ports from the state registers.
    always_comb begin
        vreg_req    = vreq_q;
        clk_div_sel = div_q;
        core_stall  = stall_q;
        busy        = (st_q != SQ_IDLE);
        cur_level   = cur_q;
    end

    // R3
    freq_le_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_lvl_q <= v_lvl_q);

    // R4
    faster_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q < $past(div_q)) |-> ($past(st_q) == SQ_UP_WAIT && $past(vreg_ack)));

    // R4
    guard_ignores_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == SQ_UP_GUARD) |-> (st_q == SQ_UP_WAIT && $stable(div_q)));

    // R5
    volt_down_after_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_lvl_q < $past(v_lvl_q)) |-> ($past(st_q) == SQ_DN_VSET && f_lvl_q == v_lvl_q));

    // R6
    stall_in_transition_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall |-> busy);

    // R7
    no_stall_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_stall) |-> (v_lvl_q > $past(v_lvl_q)));

    // R10
    idle_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (f_lvl_q == cur_q && v_lvl_q == cur_q));

    // R10
    level_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> ($fell(busy) && cur_q == $past(tgt_q)));

endmodule

// File: rtl/dvfs_seq.sv
// Top of the operating-point sequencer: request holder, lookup table and
// transition controller.
// Assumes: NUM_LEVELS >= 2; the regulator raises vreg_ack once the
// requested supply is stable and drops it after a new code appears.
module dvfs_seq #(
    parameter int NUM_LEVELS = 8,
    parameter int VW         = 8,
    parameter int V_MIN      = 60,
    parameter int V_STEP     = 10,
    localparam int LW        = $clog2(NUM_LEVELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [LW-1:0] req_level,
    input  logic          stall_mode,
    input  logic          vreg_ack,
    output logic [VW-1:0] vreg_req,
    output logic [LW-1:0] clk_div_sel,
    output logic          core_stall,
    output logic          busy,
    output logic [LW-1:0] cur_level
);

    logic          pend_vld;
    logic [LW-1:0] pend_lvl;
    logic          take;
    logic [LW-1:0] lk_idx;
    logic [VW-1:0] lk_vcode;
    logic [LW-1:0] lk_div;

    dvfs_req_hold #(.NUM_LEVELS(NUM_LEVELS), .LW(LW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_level (req_level),
        .take      (take),
        .pend_vld  (pend_vld),
        .pend_lvl  (pend_lvl)
    );

    dvfs_optable #(
        .NUM_LEVELS(NUM_LEVELS), .LW(LW), .VW(VW), .V_MIN(V_MIN), .V_STEP(V_STEP)
    ) u_table (
        .idx     (lk_idx),
        .vcode   (lk_vcode),
        .div_sel (lk_div)
    );

    dvfs_seq_fsm #(
        .NUM_LEVELS(NUM_LEVELS), .LW(LW), .VW(VW), .V_MIN(V_MIN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_vld    (pend_vld),
        .pend_lvl    (pend_lvl),
        .stall_mode  (stall_mode),
        .vreg_ack    (vreg_ack),
        .lk_vcode    (lk_vcode),
        .lk_div      (lk_div),
        .lk_idx      (lk_idx),
        .take        (take),
        .vreg_req    (vreg_req),
        .clk_div_sel (clk_div_sel),
        .core_stall  (core_stall),
        .busy        (busy),
        .cur_level   (cur_level)
    );

endmodule

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NL     = 8;
    localparam int VW     = 8;
    localparam int VMIN   = 60;
    localparam int VSTEP  = 10;
    localparam int LW     = $clog2(NL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_level = '0;
    logic          stall_mode = 1'b0;
    logic          vreg_ack;
    logic [VW-1:0] vreg_req;
    logic [LW-1:0] clk_div_sel;
    logic          core_stall;
    logic          busy;
    logic [LW-1:0] cur_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvfs_seq #(.NUM_LEVELS(NL), .VW(VW), .V_MIN(VMIN), .V_STEP(VSTEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .stall_mode(stall_mode), .vreg_ack(vreg_ack), .vreg_req(vreg_req),
        .clk_div_sel(clk_div_sel), .core_stall(core_stall), .busy(busy),
        .cur_level(cur_level)
    );

    function automatic int vcode_f(int lvl); return VMIN + lvl * VSTEP; endfunction
    function automatic int div_f(int lvl);   return NL - 1 - lvl;       endfunction
    function automatic int lvl_of(int code); return (code - VMIN) / VSTEP; endfunction
    function automatic int min2(int a, int b); return (a < b) ? a : b; endfunction

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Regulator model: drops ack the cycle after a new code, re-raises after a delay.
    int reg_delay = 2;
    int seen_code = VMIN;
    int cnt = 0;
    int settled = 0;
    int v_safe = 0;
    logic ack_q = 1'b1;
    assign vreg_ack = ack_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            seen_code <= VMIN; cnt <= 0; settled <= 0; v_safe <= 0; ack_q <= 1'b1;
        end else if (int'(vreg_req) != seen_code) begin
            seen_code <= int'(vreg_req);
            ack_q     <= 1'b0;
            cnt       <= reg_delay;
            v_safe    <= min2(settled, lvl_of(int'(vreg_req)));
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end else begin
            ack_q   <= 1'b1;
            settled <= lvl_of(seen_code);
            v_safe  <= lvl_of(seen_code);
        end
    end

    // Continuous monitors, summarised at the end.
    int safety_viol = 0;
    int idle_mismatch = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (div_f(int'(clk_div_sel)) > v_safe) safety_viol++;
            if (!busy && (int'(clk_div_sel) != div_f(int'(cur_level)) ||
                          int'(vreg_req) != vcode_f(int'(cur_level))))
                idle_mismatch++;
        end
    end

    task automatic pulse_req(int lvl, bit md);
        @(negedge clk);
        req_valid = 1'b1; req_level = LW'(lvl); stall_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int quiet = 0;
        for (int i = 0; i < 2000 && quiet < 4; i++) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    // One full request with per-transition checks.
    task automatic do_req(int lvl, bit md);
        int old = int'(cur_level);
        int old_v = int'(vreg_req);
        int old_d = int'(clk_div_sel);
        int nostall = 0, stalls = 0, lvl_moved = 0, div_bad = 0, cyc = 0;
        bit up = (lvl > old);
        pulse_req(lvl, md);
        @(negedge clk);
        if (lvl == old) begin
            for (int i = 0; i < 4; i++) begin
                if (busy) nostall++;
                if (int'(vreg_req) != old_v || int'(clk_div_sel) != old_d) div_bad++;
                @(negedge clk);
            end
            check("R8", nostall, 0, "busy cycles on equal request");
            check("R8", div_bad, 0, "output changes on equal request");
            return;
        end
        check("R10", int'(busy), 1, "busy after start");
        while (busy && cyc < 1000) begin
            cyc++;
            if (core_stall) stalls++; else nostall++;
            if (int'(cur_level) != old) lvl_moved++;
            if (up  && int'(clk_div_sel) != div_f(old)) div_bad++;
            if (!up && int'(clk_div_sel) != div_f(lvl)) div_bad++;
            @(negedge clk);
        end
        check("R10", lvl_moved, 0, "cur_level moved mid-transition");
        if (up) check("R4", div_bad, 0, "divider left old value before ack");
        else    check("R5", div_bad, 0, "divider not lowered at first edge");
        if (up && md) begin
            check("R6", nostall, 0, "unstalled cycles during stall-mode ramp");
        end else if (up) begin
            check("R7", stalls, 0, "stall cycles in running mode");
        end else begin
            check("R7", stalls, 0, "stall cycles on downward move");
        end
        check("R2", int'(cur_level), lvl, "final level");
        check("R2", int'(clk_div_sel), div_f(lvl), "final divider");
        check("R2", int'(vreg_req), vcode_f(lvl), "final supply code");
        check("R6", int'(core_stall), 0, "stall after completion");
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int dummy, rises;
        bit prev_busy;
        dummy = $urandom(32'd2718);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(cur_level), 0, "reset level");
        check("R1", int'(vreg_req), vcode_f(0), "reset supply");
        check("R1", int'(clk_div_sel), NL - 1, "reset divider");
        check("R1", int'(core_stall), 0, "reset stall");
        check("R1", int'(busy), 0, "reset busy");

        // Directed: up with stall, up without, down, top and bottom boundaries
        reg_delay = 3;
        do_req(3, 1'b1);
        do_req(NL - 1, 1'b0);
        do_req(1, 1'b1);
        do_req(0, 1'b0);
        // R8 equal request ignored
        do_req(0, 1'b1);
        // Zero-delay regulator: the guard cycle alone must keep stale ack out (R4)
        reg_delay = 0;
        do_req(5, 1'b0);
        do_req(2, 1'b1);

        // R9: two requests during a transition, only the newest served
        reg_delay = 5;
        rises = 0; prev_busy = 1'b0;
        pulse_req(NL - 1, 1'b1);
        pulse_req(4, 1'b0);
        pulse_req(6, 1'b0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (busy && !prev_busy) rises++;
            prev_busy = busy;
        end
        check("R9", int'(cur_level), 6, "level after queued requests");
        check("R9", rises, 2, "transitions served");

        // Random mix of levels, modes and regulator delays
        for (int k = 0; k < 60; k++) begin
            reg_delay = int'($urandom % 6);
            do_req(int'($urandom % NL), 1'($urandom % 2));
        end
        wait_quiet();

        check("R3", safety_viol, 0, "cycles with clock above supply");
        check("R10", idle_mismatch, 0, "idle cycles off the reported point");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule